// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block holds the pending, in-service and mask state for a group of interrupt lines, eight by default. It decides whether to raise a single interrupt line to the processor. Requests are captured on a rising edge or on a high level, depending on the trigger mode. They are then filtered by the mask and ranked by a circular priority order. Any request that is not strictly above the highest level already in service is held back, unless the special mask mode is on.

The processor answers with an acknowledge strobe that carries a first-phase flag and a last-phase flag. On the first phase the winning level moves from pending to in service, and its number appears on `ack_level` on the next cycle. Service ends in one of two ways. A command can retire either the top in-service level or a named one. Otherwise, with automatic retirement enabled, the last acknowledge phase retires it. A retiring command may also rotate the priority order so that the retired level becomes the lowest. A separate command names the lowest level directly.

Command decoding, bus handling, vector formatting and cascading stay outside this block. They reach it as decoded strobes and fields.

Top module: `prio_irq_core`

## Requirements
- R1: With `level_mode`=0, a request bit is set only by a 0-to-1 change on its line, and a line held high does not set the bit again after acknowledge. With `level_mode`=1, the request register follows the line levels each cycle.
- R2: Priority is circular, and `low_q` names the lowest level. After reset, level 0 is highest and level 7 is lowest. Outside special mask mode, `irq` is raised only for an unmasked request of strictly higher priority than the highest in-service level.
- R3: A mask bit of 1 (written through `mask_wr`/`mask_data`) keeps that line from raising `irq` or winning an acknowledge. Its request bit still reads back in `irr_q`, and lines of lower priority are not blocked.
- R4: An acknowledge strobe with `ack_first`=1 sets the in-service bit of the winning level and clears its request bit. That level is shown on `ack_level` from the next cycle on.
- R5: A command with `cmd_eoi`=1 and `cmd_specific`=0 clears the in-service bit of highest current priority.
- R6: A command with `cmd_eoi`=1 and `cmd_specific`=1 clears the in-service bit numbered by `cmd_level`.
- R7: A retiring command with `cmd_rotate`=1 makes the retired level the lowest priority, so the level after it becomes the highest.
- R8: A command with `cmd_eoi`=0 and `cmd_rotate`=1 makes `cmd_level` the lowest priority. Adding `cmd_eoi`=1 and `cmd_specific`=1 to it also clears that level's in-service bit.
- R9: With `special_mask`=1, any unmasked request whose level is not in service may raise `irq`, whatever higher levels are in service, and the order among requests still applies.
- R10: With `aeoi_en`=1, an acknowledge strobe with `ack_last`=1 clears the in-service bit of the acknowledged level. A strobe that is both first and last leaves no in-service bit set.
- R11: Reset clears the request, in-service and mask registers and restores the default priority order. After reset `irq` and `ack_level` are 0.
- R12: `irq` falls once the acknowledged request bit is cleared. It rises again as soon as another eligible request exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | NUM | Interrupt request lines |
| level_mode | input | 1 | 1: level capture, 0: rising-edge capture |
| mask_wr | input | 1 | Load mask register from `mask_data` |
| mask_data | input | NUM | New mask value, 1 blocks a line |
| special_mask | input | 1 | Lets lower levels through while higher ones are in service |
| aeoi_en | input | 1 | Retire the in-service level at the last acknowledge phase |
| cmd_valid | input | 1 | Command strobe |
| cmd_eoi | input | 1 | Command retires an in-service level |
| cmd_specific | input | 1 | Retire the level in `cmd_level` rather than the top one |
| cmd_rotate | input | 1 | Rotate priority (with retire) or set lowest level (alone) |
| cmd_level | input | log2(NUM) | Level operand of the command |
| ack | input | 1 | Acknowledge strobe |
| ack_first | input | 1 | Strobe is the first acknowledge phase |
| ack_last | input | 1 | Strobe is the last acknowledge phase |
| irq | output | 1 | Interrupt to the processor |
| ack_level | output | log2(NUM) | Level captured at the last first-phase acknowledge |
| irr_q | output | NUM | Request register readback |
| isr_q | output | NUM | In-service register readback |
| imr_q | output | NUM | Mask register readback |

## Verification
Errors in the request or in-service registers appear on their readback ports in the cycle after the stimulus that caused them. They also show at once on `irq`, which either fails to rise for a higher request or stays up when it should fall. A wrong rotation pointer cannot be read back. It shows only at the next acknowledge of two competing requests, as an unexpected `ack_level`. The scenarios therefore rotate first and then acknowledge requests whose order differs between the right pointer and a stale one.

// File: rtl/prio_irq_core.sv
module prio_irq_core #(
  parameter int NUM = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM-1:0]           req_in,
  input  logic                     level_mode,
  input  logic                     mask_wr,
  input  logic [NUM-1:0]           mask_data,
  input  logic                     special_mask,
  input  logic                     aeoi_en,
  input  logic                     cmd_valid,
  input  logic                     cmd_eoi,
  input  logic                     cmd_specific,
  input  logic                     cmd_rotate,
  input  logic [$clog2(NUM)-1:0]   cmd_level,
  input  logic                     ack,
  input  logic                     ack_first,
  input  logic                     ack_last,
  output logic                     irq,
  output logic [$clog2(NUM)-1:0]   ack_level,
  output logic [NUM-1:0]           irr_q,
  output logic [NUM-1:0]           isr_q,
  output logic [NUM-1:0]           imr_q
);
  localparam int LW = $clog2(NUM);

  logic [NUM-1:0] req_q;
  logic [LW-1:0]  low_q, cur_q;

  // Highest-priority set bit of v under a rotation whose lowest level is lo.
  function automatic logic [LW:0] top_of(input logic [NUM-1:0] v, input logic [LW-1:0] lo);
    logic [LW:0]   r;
    logic [LW-1:0] k;
    r = '0;
    for (int i = NUM - 1; i >= 0; i--) begin
      k = lo + LW'(i + 1);
      if (v[k]) r = {1'b1, k};
    end
    return r;
  endfunction

  // Levels of strictly higher priority than lvl.
  function automatic logic [NUM-1:0] above(input logic [LW-1:0] lvl, input logic [LW-1:0] lo);
    logic [NUM-1:0] m;
    logic           hit;
    logic [LW-1:0]  k;
    m = '0;
    hit = 1'b0;
    for (int i = 0; i < NUM; i++) begin
      k = lo + LW'(i + 1);
      if (k == lvl) hit = 1'b1;
      if (!hit) m[k] = 1'b1;
    end
    return m;
  endfunction

  logic [LW:0]    isr_top, win;
  logic [NUM-1:0] allowed;

  assign isr_top = top_of(isr_q, low_q);
  assign allowed = special_mask ? ~isr_q : (isr_top[LW] ? above(isr_top[LW-1:0], low_q) : '1);
  assign win     = top_of(irr_q & ~imr_q & allowed, low_q);
  assign irq     = win[LW];
  assign ack_level = cur_q;

  logic          take, nseoi, seoi, setp, eoi_hit, aeoi_clr;
  logic [LW-1:0] eoi_lvl, done_lvl;

  assign take     = ack & ack_first & win[LW];
  assign nseoi    = cmd_valid & cmd_eoi & ~cmd_specific;
  assign seoi     = cmd_valid & cmd_eoi & cmd_specific;
  assign setp     = cmd_valid & ~cmd_eoi & cmd_rotate;
  assign eoi_lvl  = cmd_specific ? cmd_level : isr_top[LW-1:0];
  assign eoi_hit  = seoi | (nseoi & isr_top[LW]);
  assign done_lvl = ack_first ? win[LW-1:0] : cur_q;
  assign aeoi_clr = aeoi_en & ack & ack_last & (win[LW] | ~ack_first);

  logic [NUM-1:0] set_v, clr_v, irr_n, isr_n;
  logic [LW-1:0]  low_n;

  always_comb begin
    set_v = take ? (NUM'(1) << win[LW-1:0]) : '0;
    clr_v = (eoi_hit ? (NUM'(1) << eoi_lvl) : '0) | (aeoi_clr ? (NUM'(1) << done_lvl) : '0);
    irr_n = (level_mode ? req_in : (irr_q | (req_in & ~req_q))) & ~set_v;
    isr_n = (isr_q | set_v) & ~clr_v;
    low_n = low_q;
    if (eoi_hit && cmd_rotate) low_n = eoi_lvl;
    else if (setp)             low_n = cmd_level;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      irr_q <= '0;
      isr_q <= '0;
      imr_q <= '0;
      low_q <= LW'(NUM - 1);
      cur_q <= '0;
    end else begin
      req_q <= req_in;
      irr_q <= irr_n;
      isr_q <= isr_n;
      low_q <= low_n;
      if (mask_wr) imr_q <= mask_data;
      if (take)    cur_q <= win[LW-1:0];
    end
  end

  assert_irq_has_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(irr_q & ~imr_q)));

  assert_ack_sets_isr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ack_first && irq && !aeoi_en && !cmd_valid) |=> isr_q[ack_level] && !irr_q[ack_level]);

  assert_nseoi_clears_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_eoi && !cmd_specific && (|isr_q) && !ack)
      |=> $countones(isr_q) == $countones($past(isr_q)) - 1);

  assert_specific_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_eoi && cmd_specific && !ack) |=> !isr_q[$past(cmd_level)]);

  assert_mask_keeps_irr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && !ack && !level_mode && !(|(req_in & ~req_q))) |=> irr_q == $past(irr_q));

  assert_aeoi_no_stuck_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (aeoi_en && ack && ack_first && ack_last && !cmd_valid) |=> isr_q == $past(isr_q));
endmodule

// File: tb/prio_irq_core_test.sv
module prio_irq_core_test;
  localparam int NUM = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NUM-1:0] req_in = '0;
  logic           level_mode = 1'b0;
  logic           mask_wr = 1'b0;
  logic [NUM-1:0] mask_data = '0;
  logic           special_mask = 1'b0;
  logic           aeoi_en = 1'b0;
  logic           cmd_valid = 1'b0, cmd_eoi = 1'b0, cmd_specific = 1'b0, cmd_rotate = 1'b0;
  logic [2:0]     cmd_level = '0;
  logic           ack = 1'b0, ack_first = 1'b0, ack_last = 1'b0;
  logic           irq;
  logic [2:0]     ack_level;
  logic [NUM-1:0] irr_q, isr_q, imr_q;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  prio_irq_core #(.NUM(NUM)) uut (
    .clk, .rst_n, .req_in, .level_mode, .mask_wr, .mask_data, .special_mask,
    .aeoi_en, .cmd_valid, .cmd_eoi, .cmd_specific, .cmd_rotate, .cmd_level,
    .ack, .ack_first, .ack_last, .irq, .ack_level, .irr_q, .isr_q, .imr_q
  );

  always #5 clk = ~clk;

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic raise(input logic [NUM-1:0] b);
    req_in = req_in | b;
    tick();
  endtask

  task automatic lower(input logic [NUM-1:0] b);
    req_in = req_in & ~b;
    tick();
  endtask

  task automatic do_ack(input logic f, input logic l);
    ack = 1'b1; ack_first = f; ack_last = l;
    tick();
    ack = 1'b0; ack_first = 1'b0; ack_last = 1'b0;
  endtask

  task automatic cmd(input logic e, input logic s, input logic r, input logic [2:0] lvl);
    cmd_valid = 1'b1; cmd_eoi = e; cmd_specific = s; cmd_rotate = r; cmd_level = lvl;
    tick();
    cmd_valid = 1'b0; cmd_eoi = 1'b0; cmd_specific = 1'b0; cmd_rotate = 1'b0;
  endtask

  task automatic set_mask(input logic [NUM-1:0] m);
    mask_wr = 1'b1; mask_data = m;
    tick();
    mask_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 irr", irr_q, 0);
    chk("R11 isr", isr_q, 0);
    chk("R11 imr", imr_q, 0);
    chk("R11 irq", irq, 0);
    chk("R11 ack_level", ack_level, 0);
  endtask

  task automatic t_fixed_order;
    raise(8'h24);
    chk("R2 irq up", irq, 1);
    do_ack(1, 1);
    chk("R4 ack_level", ack_level, 2);
    chk("R4 isr", isr_q, 8'h04);
    chk("R4 irr", irr_q, 8'h20);
    chk("R12 irq drops", irq, 0);
    cmd(1, 0, 0, 0);
    chk("R12 irq rises", irq, 1);
    do_ack(1, 1);
    chk("R4 second level", ack_level, 5);
    chk("R1 held line not re-set", irr_q, 8'h00);
    cmd(1, 0, 0, 0);
    lower(8'h24);
  endtask

  task automatic t_nesting;
    raise(8'h40);
    do_ack(1, 1);
    chk("R2 blocked", irq, 0);
    raise(8'h02);
    chk("R2 higher passes", irq, 1);
    do_ack(1, 1);
    chk("R2 nested level", ack_level, 1);
    chk("R2 nested isr", isr_q, 8'h42);
    cmd(1, 0, 0, 0);
    chk("R5 top cleared", isr_q, 8'h40);
    cmd(1, 1, 0, 6);
    chk("R6 named cleared", isr_q, 8'h00);
    lower(8'h42);
  endtask

  task automatic t_mask;
    set_mask(8'h08);
    chk("R3 imr", imr_q, 8'h08);
    raise(8'h08);
    chk("R3 irr readback", irr_q, 8'h08);
    chk("R3 masked no irq", irq, 0);
    raise(8'h10);
    chk("R3 lower passes", irq, 1);
    do_ack(1, 1);
    chk("R3 lower acked", ack_level, 4);
    cmd(1, 0, 0, 0);
    chk("R3 still masked", irq, 0);
    set_mask(8'h00);
    chk("R3 unmask irq", irq, 1);
    do_ack(1, 1);
    chk("R3 unmasked acked", ack_level, 3);
    cmd(1, 0, 0, 0);
    lower(8'h18);
    chk("R3 irr empty", irr_q, 8'h00);
  endtask

  task automatic t_level;
    level_mode = 1'b1;
    raise(8'h01);
    chk("R1 level capture", irr_q, 8'h01);
    do_ack(1, 1);
    chk("R1 ack clears", irr_q, 8'h00);
    tick();
    chk("R1 level re-set", irr_q, 8'h01);
    chk("R2 same level blocked", irq, 0);
    cmd(1, 0, 0, 0);
    chk("R12 rise after retire", irq, 1);
    lower(8'h01);
    chk("R1 level follows low", irr_q, 8'h00);
    chk("R1 irq gone", irq, 0);
    level_mode = 1'b0;
    tick();
  endtask

  task automatic t_rotate;
    raise(8'h24);
    do_ack(1, 1);
    chk("R7 first", ack_level, 2);
    cmd(1, 0, 1, 0);
    raise(8'h02);
    do_ack(1, 1);
    chk("R7 after rotate", ack_level, 5);
    cmd(1, 0, 1, 0);
    do_ack(1, 1);
    chk("R7 wrap", ack_level, 1);
    cmd(1, 0, 1, 0);
    chk("R7 isr empty", isr_q, 8'h00);
    cmd(0, 0, 1, 7);
    lower(8'h26);
  endtask

  task automatic t_set_low;
    cmd(0, 0, 1, 3);
    raise(8'h14);
    do_ack(1, 1);
    chk("R8 set lowest", ack_level, 4);
    chk("R8 lower blocked", irq, 0);
    cmd(1, 1, 1, 4);
    chk("R8 combined retire", isr_q, 8'h00);
    lower(8'h10);
    raise(8'h10);
    do_ack(1, 1);
    chk("R8 new order", ack_level, 2);
    chk("R8 four now lowest", irq, 0);
    cmd(1, 1, 0, 2);
    do_ack(1, 1);
    chk("R8 last", ack_level, 4);
    cmd(1, 1, 0, 4);
    cmd(0, 0, 1, 7);
    lower(8'h14);
  endtask

  task automatic t_special;
    raise(8'h02);
    do_ack(1, 1);
    raise(8'h48);
    chk("R9 off blocks", irq, 0);
    special_mask = 1'b1;
    tick();
    chk("R9 on passes", irq, 1);
    do_ack(1, 1);
    chk("R9 order kept", ack_level, 3);
    chk("R9 isr", isr_q, 8'h0A);
    chk("R9 next lower", irq, 1);
    do_ack(1, 1);
    chk("R9 lowest", ack_level, 6);
    special_mask = 1'b0;
    cmd(1, 1, 0, 1);
    cmd(1, 1, 0, 3);
    cmd(1, 1, 0, 6);
    chk("R6 all retired", isr_q, 8'h00);
    lower(8'h4A);
  endtask

  task automatic t_aeoi;
    aeoi_en = 1'b1;
    raise(8'h08);
    do_ack(1, 0);
    chk("R10 first phase", isr_q, 8'h08);
    chk("R10 level", ack_level, 3);
    do_ack(0, 1);
    chk("R10 last phase", isr_q, 8'h00);
    raise(8'h20);
    do_ack(1, 1);
    chk("R10 single pulse isr", isr_q, 8'h00);
    chk("R10 single pulse irr", irr_q, 8'h00);
    chk("R10 single pulse level", ack_level, 5);
    aeoi_en = 1'b0;
    lower(8'h28);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_fixed_order();
    t_nesting();
    t_mask();
    t_level();
    t_rotate();
    t_set_low();
    t_special();
    t_aeoi();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule